// File: doc/BRIEF.md
# Routable Interrupt Controller with Software Sources

This controller gathers a bank of hardware interrupt lines and a bank of software-raised sources and steers each of them to one of a few output interrupt lines. Every source owns a configuration word that holds an enable bit, a target-thread tag and an output-line selector. Each output line is driven high while at least one enabled source routed to it has its pending bit set.

Software reaches the block through a plain 64-bit register port that has four regions. The configuration region is indexed by source number. The pending-read window returns one 64-bit word of raw pending state. The set window and the clear window raise and drop software pending bits, with one data bit per source in the addressed word. Hardware sources hold the lowest indices. Software sources start at index 64, in the next pending word.

Top module: `route_intc`

## Requirements
- R1: A configuration write at source index i (region code 0, index port = i) changes only the configuration of source i. Reading region 0 at index i returns that source's word.
- R2: The configuration word keeps the enable in bit 31, the target-thread tag in bits 30..8 and the output-line selector in bits 3..0, and reads back exactly what was written in those fields.
- R3: Configuration bits 63..32 and 7..4 always read as zero, whatever was written to them.
- R4: Pending word 0 holds the hardware sources 0..63. Each of its bits follows the matching hardware input, sampled at every clock edge, so the input reaches the pending state and the outputs one cycle after it changes.
- R5: A write to the set window (region code 2) at pending word 1 sets each software pending bit whose data bit is 1 and leaves the other bits unchanged.
- R6: A write to the clear window (region code 3) at pending word 1 clears each software pending bit whose data bit is 1 and leaves the other bits unchanged.
- R7: Set-window and clear-window writes that address a hardware word or a word past the last one change no pending state.
- R8: Output line k is the OR of the pending bits of all enabled sources whose selector equals k. A selector of 6 or more drives no output.
- R9: A source with its enable bit at 0 drives no output line, even while it is pending.
- R10: A read of the pending window (region code 1) at word w returns the raw pending bits of that word, whatever the enable state. A word index past the last word reads as zero.
- R11: After reset every configuration word, every software pending bit and every output line is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hwIrq | input | 64 | Hardware interrupt lines, level sensitive |
| reqValid | input | 1 | Register access in this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRegion | input | 2 | 0 config, 1 pending read, 2 set, 3 clear |
| reqIndex | input | 7 | Source index (config) or pending word index |
| reqWdata | input | 64 | Write data |
| rdData | output | 64 | Read data, valid in the same cycle as a read access, zero otherwise |
| irqOut | output | 6 | Routed output interrupt lines |

## Verification
The assertions assume that the register port carries at most one access per cycle, as a single region code and index. The write-one-to-set and write-one-to-clear checks therefore never see a set and a clear to the same word at once. They also assume that the port is idle while reset is held. The stimulus drives the port only between clock edges and keeps every request to one cycle. Its random phase draws indices across the full index range, including pending-word indices that lie past the last word, so the ignore paths are exercised inside those limits.

// File: rtl/route_intc_pkg.sv
package route_intc_pkg;

  localparam int WORD_W = 64;
  localparam int TID_W  = 23;
  localparam int LINE_W = 4;

  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_PEND = 2'd1,
    REG_SET  = 2'd2,
    REG_CLR  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              en;
    logic [TID_W-1:0]  tid;
    logic [LINE_W-1:0] line;
  } cfg_t;

  typedef struct packed {
    logic cfgWr;
    logic setWr;
    logic clrWr;
    logic rdCfg;
    logic rdPend;
  } strobe_t;

endpackage

// File: rtl/route_intc_ctrl.sv
module route_intc_ctrl
  import route_intc_pkg::*;
#(
  parameter int HW_WORDS = 1,
  parameter int SW_WORDS = 1
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic                                       reqValid,
  input  logic                                       reqWrite,
  input  logic [1:0]                                 reqRegion,
  input  logic [$clog2((HW_WORDS+SW_WORDS)*64)-1:0]  reqIndex,
  output strobe_t                                    stb
);
  localparam int NUM_WORDS = HW_WORDS + SW_WORDS;
  localparam int NUM_SRC   = NUM_WORDS * 64;

  logic cfgIdxOk;
  logic softWord;
  logic anyWord;
  regSel_e sel;

  assign sel      = regSel_e'(reqRegion);
  assign cfgIdxOk = int'(reqIndex) < NUM_SRC;
  assign anyWord  = int'(reqIndex) < NUM_WORDS;
  assign softWord = anyWord && (int'(reqIndex) >= HW_WORDS);

  always_comb begin
    stb = '0;
    if (reqValid) begin
      unique case (sel)
        REG_CFG:  begin
          stb.cfgWr = reqWrite && cfgIdxOk;
          stb.rdCfg = !reqWrite && cfgIdxOk;
        end
        REG_PEND: stb.rdPend = !reqWrite && anyWord;
        REG_SET:  stb.setWr  = reqWrite && softWord;
        REG_CLR:  stb.clrWr  = reqWrite && softWord;
        default:  stb = '0;
      endcase
    end
  end

  // R1: a single access produces at most one strobe
  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cfgWr, stb.setWr, stb.clrWr, stb.rdCfg, stb.rdPend}));

endmodule

// File: rtl/route_intc_datapath.sv
module route_intc_datapath
  import route_intc_pkg::*;
#(
  parameter int HW_WORDS = 1,
  parameter int SW_WORDS = 1
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  strobe_t                                    stb,
  input  logic [$clog2((HW_WORDS+SW_WORDS)*64)-1:0]  idx,
  input  logic [WORD_W-1:0]                          wdata,
  input  logic [HW_WORDS*64-1:0]                     hwIrq,
  output logic [WORD_W-1:0]                          rdData,
  output cfg_t [(HW_WORDS+SW_WORDS)*64-1:0]          cfgArr,
  output logic [(HW_WORDS+SW_WORDS)*64-1:0]          pendFlat
);
  localparam int NUM_WORDS = HW_WORDS + SW_WORDS;
  localparam int NUM_SRC   = NUM_WORDS * 64;

  cfg_t        cfgMem  [NUM_SRC];
  logic [63:0] pendWord [NUM_WORDS];

  // configuration storage: only the defined fields are kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SRC; s++) cfgMem[s] <= '0;
    end else if (stb.cfgWr) begin
      cfgMem[idx].en   <= wdata[31];
      cfgMem[idx].tid  <= wdata[30:8];
      cfgMem[idx].line <= wdata[3:0];
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) cfgArr[s] = cfgMem[s];
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [63:0] wordQ;
    if (w < HW_WORDS) begin : g_hard
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) wordQ <= '0;
        else       wordQ <= hwIrq[w*64 +: 64];
      end
    end else begin : g_soft
      logic hit;
      assign hit = (int'(idx) == w);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  wordQ <= '0;
        else if (stb.setWr && hit)  wordQ <= wordQ | wdata;
        else if (stb.clrWr && hit)  wordQ <= wordQ & ~wdata;
      end

      // R5: every requested bit is set one cycle later
      p_set_bits_r5: assert property (@(posedge clk) disable iff (!rstN)
        (stb.setWr && hit) |=> ((wordQ & $past(wdata)) == $past(wdata)));
      // R6: every requested bit is clear one cycle later
      p_clr_bits_r6: assert property (@(posedge clk) disable iff (!rstN)
        (stb.clrWr && hit) |=> ((wordQ & $past(wdata)) == '0));
      // R7: without a set or clear aimed at this word it holds its value
      p_soft_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
        !((stb.setWr || stb.clrWr) && hit) |=> $stable(wordQ));
    end
    assign pendWord[w] = wordQ;
    assign pendFlat[w*64 +: 64] = wordQ;
  end

  // R1: configuration holds without a configuration write
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cfgWr |=> $stable(cfgArr));

  always_comb begin
    rdData = '0;
    if (stb.rdCfg) begin
      rdData[31]   = cfgMem[idx].en;
      rdData[30:8] = cfgMem[idx].tid;
      rdData[3:0]  = cfgMem[idx].line;
    end else if (stb.rdPend) begin
      rdData = pendWord[idx[$clog2(NUM_WORDS+1)-1:0] % NUM_WORDS];
    end
  end

  // R3: reserved configuration bits never appear on a read
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdCfg |-> (rdData[63:32] == '0 && rdData[7:4] == '0));

endmodule

// File: rtl/route_intc_router.sv
module route_intc_router
  import route_intc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int NUM_OUT = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfg_t [NUM_SRC-1:0]  cfgArr,
  input  logic [NUM_SRC-1:0]  pendFlat,
  output logic [NUM_OUT-1:0]  irqOut
);
  logic [NUM_SRC-1:0] enVec;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) enVec[s] = cfgArr[s].en;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    always_comb begin
      irqOut[k] = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (cfgArr[s].en && cfgArr[s].line == LINE_W'(k))
          irqOut[k] = irqOut[k] | pendFlat[s];
      end
    end
  end

  // R9: with every source disabled no output line is driven
  p_disabled_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enVec == '0) |-> (irqOut == '0));
  // R8: nothing pending means no output
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pendFlat == '0) |-> (irqOut == '0));

endmodule

// File: rtl/route_intc.sv
module route_intc
  import route_intc_pkg::*;
#(
  parameter int HW_WORDS = 1,
  parameter int SW_WORDS = 1,
  parameter int NUM_OUT  = 6,
  localparam int NUM_SRC = (HW_WORDS + SW_WORDS) * 64,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [HW_WORDS*64-1:0] hwIrq,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [1:0]           reqRegion,
  input  logic [IDX_W-1:0]     reqIndex,
  input  logic [WORD_W-1:0]    reqWdata,
  output logic [WORD_W-1:0]    rdData,
  output logic [NUM_OUT-1:0]   irqOut
);
  strobe_t              stb;
  cfg_t [NUM_SRC-1:0]   cfgArr;
  logic [NUM_SRC-1:0]   pendFlat;

  route_intc_ctrl #(.HW_WORDS(HW_WORDS), .SW_WORDS(SW_WORDS)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRegion(reqRegion), .reqIndex(reqIndex), .stb(stb)
  );

  route_intc_datapath #(.HW_WORDS(HW_WORDS), .SW_WORDS(SW_WORDS)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(reqIndex), .wdata(reqWdata),
    .hwIrq(hwIrq), .rdData(rdData), .cfgArr(cfgArr), .pendFlat(pendFlat)
  );

  route_intc_router #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) i_router (
    .clk(clk), .rstN(rstN), .cfgArr(cfgArr), .pendFlat(pendFlat),
    .irqOut(irqOut)
  );

endmodule

// File: tb/test_route_intc.sv
`timescale 1ns/1ps
module test_route_intc;
  localparam int NSRC = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] hwIrq = '0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqRegion = '0;
  logic [6:0]  reqIndex = '0;
  logic [63:0] reqWdata = '0;
  logic [63:0] rdData;
  logic [5:0]  irqOut;

  int checks = 0;
  int fails  = 0;

  bit        mEn   [NSRC];
  bit [22:0] mTid  [NSRC];
  bit [3:0]  mLine [NSRC];
  bit [63:0] mPend [2];

  always #2.5 clk = ~clk;

  route_intc i_route_intc (
    .clk(clk), .rstN(rstN), .hwIrq(hwIrq), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqRegion(reqRegion), .reqIndex(reqIndex),
    .reqWdata(reqWdata), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [5:0] expOut();
    logic [5:0] o = '0;
    for (int s = 0; s < NSRC; s++)
      if (mEn[s] && mPend[s/64][s%64] && mLine[s] < 6) o[mLine[s]] = 1'b1;
    return o;
  endfunction

  function automatic logic [63:0] expRead();
    logic [63:0] r = '0;
    if (reqValid && !reqWrite) begin
      if (reqRegion == 2'd0)
        r = {32'b0, mEn[reqIndex], mTid[reqIndex], 4'b0, mLine[reqIndex]};
      else if (reqRegion == 2'd1 && reqIndex < 2)
        r = mPend[reqIndex];
    end
    return r;
  endfunction

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step();
    @(posedge clk);
    if (reqValid && reqWrite) begin
      case (reqRegion)
        2'd0: begin
          mEn[reqIndex]   = reqWdata[31];
          mTid[reqIndex]  = reqWdata[30:8];
          mLine[reqIndex] = reqWdata[3:0];
        end
        2'd2: if (reqIndex == 1) mPend[1] = mPend[1] | reqWdata;
        2'd3: if (reqIndex == 1) mPend[1] = mPend[1] & ~reqWdata;
        default: ;
      endcase
    end
    mPend[0] = hwIrq;
    @(negedge clk);
    check("R8 routing", {58'b0, irqOut}, {58'b0, expOut()});
  endtask

  task automatic wr(logic [1:0] reg_, logic [6:0] idx, logic [63:0] d);
    reqValid = 1'b1; reqWrite = 1'b1; reqRegion = reg_; reqIndex = idx; reqWdata = d;
    step();
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic rd(logic [1:0] reg_, logic [6:0] idx, logic [63:0] exp, string tag);
    reqValid = 1'b1; reqWrite = 1'b0; reqRegion = reg_; reqIndex = idx;
    #1;
    check(tag, rdData, exp);
    check({tag, " model"}, rdData, expRead());
    step();
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #900000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int s = 0; s < NSRC; s++) begin mEn[s] = 0; mTid[s] = 0; mLine[s] = 0; end
    mPend[0] = 0; mPend[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    check("R11 outputs", {58'b0, irqOut}, 64'h0);
    rd(2'd0, 7'd0,   64'h0, "R11 cfg0");
    rd(2'd0, 7'd127, 64'h0, "R11 cfg127");
    rd(2'd1, 7'd1,   64'h0, "R11 soft pending");
    // R2 / R3 field packing with reserved bits written as ones
    wr(2'd0, 7'd3, 64'hFFFF_FFFF_8123_45F2);
    rd(2'd0, 7'd3, 64'h0000_0000_8123_4502, "R2 R3 cfg fields");
    rd(2'd0, 7'd4, 64'h0, "R1 neighbour untouched");
    // R4 hardware source 3 routed to line 2
    hwIrq = 64'h8;
    step();
    check("R4 hw to line2", {58'b0, irqOut}, 64'h4);
    rd(2'd1, 7'd0, 64'h8, "R4 hw pending");
    // R9 disabled source, R10 raw pending
    wr(2'd0, 7'd10, 64'h0000_0000_0000_0002);
    hwIrq = 64'h400;
    step();
    check("R9 disabled silent", {58'b0, irqOut}, 64'h0);
    rd(2'd1, 7'd0, 64'h400, "R10 raw pending");
    hwIrq = 64'h0;
    // R5 / R6 software source 69 on line 0
    wr(2'd0, 7'd69, 64'h0000_0000_8000_0000);
    wr(2'd2, 7'd1, 64'hA0);
    check("R5 soft to line0", {58'b0, irqOut}, 64'h1);
    rd(2'd1, 7'd1, 64'hA0, "R5 set bits");
    wr(2'd3, 7'd1, 64'h20);
    rd(2'd1, 7'd1, 64'h80, "R6 clear bit");
    check("R6 line dropped", {58'b0, irqOut}, 64'h0);
    // R7 set/clear aimed at hardware or missing words
    wr(2'd2, 7'd0, '1);
    rd(2'd1, 7'd1, 64'h80, "R7 set on hw word");
    wr(2'd3, 7'd0, '1);
    rd(2'd1, 7'd1, 64'h80, "R7 clear on hw word");
    wr(2'd2, 7'd5, '1);
    rd(2'd1, 7'd1, 64'h80, "R7 set past end");
    rd(2'd1, 7'd5, 64'h0, "R10 past end reads zero");
    // R8 selector 7 drives nothing
    wr(2'd0, 7'd73, 64'h0000_0000_8000_0007);
    wr(2'd2, 7'd1, 64'h200);
    check("R8 line7 none", {58'b0, irqOut}, 64'h0);
    // R8 OR of a hardware and a software source on line 5
    wr(2'd0, 7'd71, 64'h0000_0000_8000_0005);
    check("R8 soft on line5", {58'b0, irqOut}, 64'h20);
    wr(2'd0, 7'd3, 64'h0000_0000_8000_0005);
    hwIrq = 64'h8;
    step();
    wr(2'd3, 7'd1, 64'h80);
    check("R8 hw keeps line5", {58'b0, irqOut}, 64'h20);
    hwIrq = 64'h0;
    step();
    check("R8 line5 low", {58'b0, irqOut}, 64'h0);
    // random phase against the model
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] d;
      hwIrq = {$urandom, $urandom} & {$urandom, $urandom};
      reqValid = ($urandom % 3) != 0;
      reqWrite = $urandom % 2;
      reqRegion = $urandom % 4;
      reqIndex = ($urandom % 2) ? 7'($urandom % 4) : 7'($urandom);
      d = {$urandom, $urandom};
      if (reqRegion == 2'd0) d[3:0] = 4'($urandom % 8);
      reqWdata = d;
      #1;
      check("R1 R10 random read", rdData, expRead());
      step();
    end
    reqValid = 1'b0;
    finishRun();
  end
endmodule